// File: doc/BRIEF.md
# USB Data Packet Sequencer

This block handles the data stage of a USB transaction on the host side, once a token has gone out. It works on a bit-serial NRZ stream in which stuffing has already been applied on the way out or removed on the way in. A bit-time strobe paces every step. In transmit it reads payload bytes from one of two byte-wide endpoint buffers and serializes the whole packet. In receive it recognises the start of a packet, checks the data PID against the expected toggle, writes the payload into one of the two buffers, checks the CRC16 residue and enforces the buffer's size limit.

Two inputs control each transfer. The toggle bit selects DATA0 or DATA1. The direction bit selects the buffer, and the receive side uses the opposite mapping from the transmit side. Errors are held in sticky flags that software clears. If a flag is not cleared, a new cause from a later receive is ORed into it. A one-cycle done pulse marks the end of each packet, and a count output reports how many payload bytes arrived.

Top module: `usb_dp_seq`

## Requirements
- R1: A transmit sends, one bit per strobe period:
  - 8 sync bits (0,0,0,0,0,0,0,1);
  - the 8 PID bits, LSB first;
  - each payload byte, LSB first;
  - 16 CRC bits;
  - 2 bit times of SE0 (tx_se0=1, tx_bit=0);
  - 1 bit time of J (tx_bit=1, tx_se0=0).
  
  After that tx_oe drops.
- R2: The transmitted PID is 0xC3 (DATA0) when toggle is 0 and 0x4B (DATA1) when toggle is 1.
- R3: On transmit, dir=1 reads endpoint buffer 1 (rd_buf=0) and dir=0 reads endpoint buffer 2 (rd_buf=1). The number of payload bytes sent equals that buffer's size input (0 to 2^ADDR_W).
- R4: On receive, dir=1 writes endpoint buffer 2 (wr_buf=1) and dir=0 writes endpoint buffer 1 (wr_buf=0). Payload byte i is written at address i. The two CRC bytes are never written.
- R5: On receive, if the PID byte is not the one selected by toggle, err_tog is set and no byte is written.
- R6: The CRC uses x^16+x^15+x^2+1 and is preset to 0xFFFF.
  - Transmit sends the complemented register, bit 15 first.
  - Receive runs the CRC over payload and CRC bits. Any final value other than 0x800D sets err_crc.
- R7: On receive, if the payload byte count exceeds the selected buffer's size input, err_size is set. Only bytes at addresses below the limit are written.
- R8: err_tog, err_crc and err_size each stay set until their clr_* input is pulsed. A cause from a later receive is ORed into a flag that was not cleared.
- R9: done is a one-cycle pulse, in the cycle after the J bit time on transmit and in the cycle after rx_eop on receive. rx_count then holds the received payload byte count.
- R10: After reset, tx_oe, tx_bit, tx_se0, wr_en, done, all error flags and rx_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_tx | input | 1 | Begin sending a data packet |
| start_rx | input | 1 | Begin receiving a data packet |
| toggle | input | 1 | Expected or sent data toggle |
| dir | input | 1 | Buffer selector, mapping depends on transfer direction |
| size_ep1 | input | ADDR_W+1 | Size of endpoint buffer 1 (send length / receive limit) |
| size_ep2 | input | ADDR_W+1 | Size of endpoint buffer 2 (send length / receive limit) |
| bit_stb | input | 1 | One-cycle strobe per bit time |
| tx_oe | output | 1 | Transmit stream active |
| tx_bit | output | 1 | Transmit NRZ bit |
| tx_se0 | output | 1 | Transmit single-ended zero |
| rd_buf | output | 1 | Buffer read select (0 = buffer 1, 1 = buffer 2) |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_data | input | 8 | Buffer read data, same cycle |
| rx_bit | input | 1 | Received NRZ bit, valid with bit_stb |
| rx_eop | input | 1 | End of received packet seen |
| wr_en | output | 1 | Buffer write strobe |
| wr_buf | output | 1 | Buffer write select (0 = buffer 1, 1 = buffer 2) |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| clr_tog | input | 1 | Clear toggle error flag |
| clr_crc | input | 1 | Clear CRC error flag |
| clr_size | input | 1 | Clear size error flag |
| err_tog | output | 1 | Sticky toggle error |
| err_crc | output | 1 | Sticky CRC error |
| err_size | output | 1 | Sticky size error |
| done | output | 1 | Packet complete pulse |
| rx_count | output | ADDR_W+2 | Payload bytes of the last receive |

## Verification
The assertions check the following on every cycle:
- the transmitted sync begins with a low bit;
- J always follows the end of SE0;
- done never lasts two cycles;
- no write ever lands at or beyond the receive limit or after a bad PID;
- an uncleared error flag never drops.

Only the bench's scenarios can show the rest. They loop each transmitted stream back into the receiver, which exercises the exact bit order, the PID values, the buffer selection in each direction, the CRC residue on clean and corrupted packets, the size boundary at equality and above it, and the merging of causes across back-to-back packets.

// File: rtl/usb_dp_pkg.sv
package usb_dp_pkg;

    localparam logic [7:0]  SYNC_PAT  = 8'h80;
    localparam logic [7:0]  PID_DATA0 = 8'hC3;
    localparam logic [7:0]  PID_DATA1 = 8'h4B;
    localparam logic [15:0] CRC_POLY  = 16'h8005;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD  = 16'h800D;

    typedef enum logic [2:0] {
        TX_IDLE, TX_SYNC, TX_PID, TX_DATA, TX_CRC, TX_EOP, TX_J, TX_DONE
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_SYNC, RX_PID, RX_DATA, RX_DONE
    } rx_state_e;

    // one serial step of the CRC16 shift register
    function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

    function automatic logic [7:0] data_pid(input logic tog);
        return tog ? PID_DATA1 : PID_DATA0;
    endfunction

endpackage

// File: rtl/usb_dp_tx.sv
module usb_dp_tx
    import usb_dp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              toggle,
    input  logic              dir,
    input  logic [ADDR_W:0]   size1,
    input  logic [ADDR_W:0]   size2,
    input  logic              bit_stb,
    input  logic [7:0]        rd_data,
    output logic              rd_buf,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tx_oe,
    output logic              tx_bit,
    output logic              tx_se0,
    output logic              done
);
    localparam int CNT_W = ADDR_W + 1;

    typedef struct packed {
        tx_state_e        st;
        logic [3:0]       bitc;
        logic [CNT_W-1:0] nbyte;
        logic [CNT_W-1:0] len;
        logic [15:0]      crc;
        logic             sel;
        logic [7:0]       pid;
    } tx_reg_t;

    tx_reg_t q, d;
    logic cur_bit, oe_c, se0_c;
    logic [CNT_W-1:0] nbyte_inc;

    always_comb begin
        d         = q;
        cur_bit   = 1'b0;
        oe_c      = 1'b1;
        se0_c     = 1'b0;
        nbyte_inc = q.nbyte + {{(CNT_W-1){1'b0}}, 1'b1};
        case (q.st)
            TX_IDLE: begin
                oe_c = 1'b0;
                if (start) begin
                    d.st    = TX_SYNC;
                    d.bitc  = 4'd0;
                    d.nbyte = '0;
                    d.crc   = CRC_INIT;
                    d.sel   = ~dir;
                    d.len   = dir ? size1 : size2;
                    d.pid   = data_pid(toggle);
                end
            end
            TX_SYNC: begin
                cur_bit = SYNC_PAT[q.bitc[2:0]];
                if (bit_stb) begin
                    if (q.bitc == 4'd7) begin
                        d.st   = TX_PID;
                        d.bitc = 4'd0;
                    end else begin
                        d.bitc = q.bitc + 4'd1;
                    end
                end
            end
            TX_PID: begin
                cur_bit = q.pid[q.bitc[2:0]];
                if (bit_stb) begin
                    if (q.bitc == 4'd7) begin
                        d.bitc = 4'd0;
                        d.st   = (q.len == '0) ? TX_CRC : TX_DATA;
                    end else begin
                        d.bitc = q.bitc + 4'd1;
                    end
                end
            end
            TX_DATA: begin
                cur_bit = rd_data[q.bitc[2:0]];
                if (bit_stb) begin
                    d.crc = crc16_next(q.crc, cur_bit);
                    if (q.bitc == 4'd7) begin
                        d.bitc  = 4'd0;
                        d.nbyte = nbyte_inc;
                        if (nbyte_inc == q.len) d.st = TX_CRC;
                    end else begin
                        d.bitc = q.bitc + 4'd1;
                    end
                end
            end
            TX_CRC: begin
                cur_bit = ~q.crc[4'd15 - q.bitc];
                if (bit_stb) begin
                    if (q.bitc == 4'd15) begin
                        d.st   = TX_EOP;
                        d.bitc = 4'd0;
                    end else begin
                        d.bitc = q.bitc + 4'd1;
                    end
                end
            end
            TX_EOP: begin
                se0_c = 1'b1;
                if (bit_stb) begin
                    if (q.bitc == 4'd1) begin
                        d.st   = TX_J;
                        d.bitc = 4'd0;
                    end else begin
                        d.bitc = q.bitc + 4'd1;
                    end
                end
            end
            TX_J: begin
                cur_bit = 1'b1;
                if (bit_stb) d.st = TX_DONE;
            end
            TX_DONE: begin
                oe_c = 1'b0;
                d.st = TX_IDLE;
            end
            default: begin
                oe_c = 1'b0;
                d.st = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TX_IDLE, bitc: 4'd0, nbyte: '0, len: '0,
                   crc: CRC_INIT, sel: 1'b0, pid: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign tx_oe   = oe_c;
    assign tx_bit  = oe_c & cur_bit;
    assign tx_se0  = se0_c;
    assign rd_buf  = q.sel;
    assign rd_addr = q.nbyte[ADDR_W-1:0];
    assign done    = (q.st == TX_DONE);

    // R1: a packet opens with a low sync bit
    assert_sync_starts_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> !tx_bit);

    // R1: the end of SE0 is followed by a J bit time
    assert_j_after_eop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_se0) |-> (tx_oe && tx_bit));

    // R9: completion is a single-cycle pulse
    assert_tx_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/usb_dp_rx.sv
module usb_dp_rx
    import usb_dp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              toggle,
    input  logic              dir,
    input  logic [ADDR_W:0]   size1,
    input  logic [ADDR_W:0]   size2,
    input  logic              bit_stb,
    input  logic              rx_bit,
    input  logic              rx_eop,
    output logic              wr_en,
    output logic              wr_buf,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              tog_err,
    output logic              crc_err,
    output logic              size_err,
    output logic [ADDR_W+1:0] count
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int NB_W  = ADDR_W + 2;

    typedef struct packed {
        rx_state_e        st;
        logic [2:0]       bitc;
        logic [7:0]       sh;
        logic [7:0]       h0;
        logic [7:0]       h1;
        logic [NB_W-1:0]  nb;
        logic [CNT_W-1:0] lim;
        logic [15:0]      crc;
        logic             sel;
        logic             pid_ok;
        logic             tog_e;
        logic             crc_e;
        logic             size_e;
        logic [NB_W-1:0]  cnt;
        logic             wen;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]       wdata;
    } rx_reg_t;

    rx_reg_t q, d;
    logic [7:0]      byte_new;
    logic [NB_W-1:0] nb_inc, widx, payload, lim_x;
    logic            finish;

    always_comb begin
        d        = q;
        d.wen    = 1'b0;
        byte_new = {rx_bit, q.sh[7:1]};
        nb_inc   = (&q.nb) ? q.nb : q.nb + {{(NB_W-1){1'b0}}, 1'b1};
        widx     = q.nb - {{(NB_W-2){1'b0}}, 2'd2};
        payload  = (q.nb >= {{(NB_W-2){1'b0}}, 2'd2}) ? widx : '0;
        lim_x    = {1'b0, q.lim};
        finish   = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (start) begin
                    d.st     = RX_SYNC;
                    d.bitc   = 3'd0;
                    d.nb     = '0;
                    d.crc    = CRC_INIT;
                    d.sel    = dir;
                    d.lim    = dir ? size2 : size1;
                    d.pid_ok = 1'b0;
                    d.tog_e  = 1'b0;
                    d.crc_e  = 1'b0;
                    d.size_e = 1'b0;
                end
            end
            RX_SYNC: begin
                if (rx_eop) finish = 1'b1;
                else if (bit_stb && rx_bit) begin
                    d.st   = RX_PID;
                    d.bitc = 3'd0;
                end
            end
            RX_PID: begin
                if (rx_eop) finish = 1'b1;
                else if (bit_stb) begin
                    d.sh   = byte_new;
                    d.bitc = q.bitc + 3'd1;
                    if (q.bitc == 3'd7) begin
                        d.pid_ok = (byte_new == data_pid(toggle));
                        d.st     = RX_DATA;
                    end
                end
            end
            RX_DATA: begin
                if (rx_eop) finish = 1'b1;
                else if (bit_stb) begin
                    d.crc  = crc16_next(q.crc, rx_bit);
                    d.sh   = byte_new;
                    d.bitc = q.bitc + 3'd1;
                    if (q.bitc == 3'd7) begin
                        // the byte two places back is known to be payload
                        if ((q.nb >= {{(NB_W-2){1'b0}}, 2'd2}) && q.pid_ok && (widx < lim_x)) begin
                            d.wen   = 1'b1;
                            d.waddr = widx[ADDR_W-1:0];
                            d.wdata = q.h1;
                        end
                        d.h1 = q.h0;
                        d.h0 = byte_new;
                        d.nb = nb_inc;
                    end
                end
            end
            RX_DONE: d.st = RX_IDLE;
            default: d.st = RX_IDLE;
        endcase
        if (finish) begin
            d.st     = RX_DONE;
            d.tog_e  = ~q.pid_ok;
            d.crc_e  = (q.crc != CRC_GOOD);
            d.size_e = (payload > lim_x);
            d.cnt    = payload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, bitc: 3'd0, sh: 8'h00, h0: 8'h00, h1: 8'h00,
                   nb: '0, lim: '0, crc: CRC_INIT, sel: 1'b0, pid_ok: 1'b0,
                   tog_e: 1'b0, crc_e: 1'b0, size_e: 1'b0, cnt: '0,
                   wen: 1'b0, waddr: '0, wdata: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign wr_en    = q.wen;
    assign wr_buf   = q.sel;
    assign wr_addr  = q.waddr;
    assign wr_data  = q.wdata;
    assign done     = (q.st == RX_DONE);
    assign tog_err  = q.tog_e;
    assign crc_err  = q.crc_e;
    assign size_err = q.size_e;
    assign count    = q.cnt;

    // R7: a write never reaches the receive limit
    assert_write_in_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < q.lim));

    // R5: a rejected PID suppresses every following write
    assert_no_write_bad_pid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_DATA && !q.pid_ok) |=> !wr_en);

    // R9: completion is a single-cycle pulse
    assert_rx_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/usb_dp_seq.sv
module usb_dp_seq
    import usb_dp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic              toggle,
    input  logic              dir,
    input  logic [ADDR_W:0]   size_ep1,
    input  logic [ADDR_W:0]   size_ep2,
    input  logic              bit_stb,
    output logic              tx_oe,
    output logic              tx_bit,
    output logic              tx_se0,
    output logic              rd_buf,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              rx_bit,
    input  logic              rx_eop,
    output logic              wr_en,
    output logic              wr_buf,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              clr_tog,
    input  logic              clr_crc,
    input  logic              clr_size,
    output logic              err_tog,
    output logic              err_crc,
    output logic              err_size,
    output logic              done,
    output logic [ADDR_W+1:0] rx_count
);
    typedef struct packed {
        logic tog;
        logic crc;
        logic size;
    } flag_t;

    flag_t q, d;
    logic  tx_done, rx_done, c_tog, c_crc, c_size;

    usb_dp_tx #(.ADDR_W(ADDR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(start_tx), .toggle(toggle), .dir(dir),
        .size1(size_ep1), .size2(size_ep2), .bit_stb(bit_stb), .rd_data(rd_data),
        .rd_buf(rd_buf), .rd_addr(rd_addr), .tx_oe(tx_oe), .tx_bit(tx_bit),
        .tx_se0(tx_se0), .done(tx_done)
    );

    usb_dp_rx #(.ADDR_W(ADDR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .start(start_rx), .toggle(toggle), .dir(dir),
        .size1(size_ep1), .size2(size_ep2), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .rx_eop(rx_eop), .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(rx_done), .tog_err(c_tog), .crc_err(c_crc),
        .size_err(c_size), .count(rx_count)
    );

    always_comb begin
        d      = q;
        d.tog  = (q.tog  & ~clr_tog)  | (rx_done & c_tog);
        d.crc  = (q.crc  & ~clr_crc)  | (rx_done & c_crc);
        d.size = (q.size & ~clr_size) | (rx_done & c_size);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err_tog  = q.tog;
    assign err_crc  = q.crc;
    assign err_size = q.size;
    assign done     = tx_done | rx_done;

    // R8: flags drop only through their clear input
    assert_sticky_tog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_tog && !clr_tog) |=> err_tog);
    assert_sticky_crc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_crc && !clr_crc) |=> err_crc);
    assert_sticky_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_size && !clr_size) |=> err_size);

endmodule

// File: tb/sim_usb_dp_seq.sv
module sim_usb_dp_seq;

    localparam int AW = 6;

    typedef struct packed {
        logic       txdir;
        logic       txtog;
        logic [6:0] txlen;
        logic       rxdir;
        logic       rxtog;
        logic [6:0] rxlim;
        logic       flip;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 7'd4,  1'b1, 1'b0, 7'd8,  1'b0},
        '{1'b0, 1'b1, 7'd5,  1'b0, 1'b1, 7'd5,  1'b0},
        '{1'b1, 1'b1, 7'd3,  1'b0, 1'b0, 7'd8,  1'b0},
        '{1'b0, 1'b0, 7'd6,  1'b1, 1'b0, 7'd4,  1'b0},
        '{1'b1, 1'b0, 7'd2,  1'b1, 1'b0, 7'd8,  1'b1},
        '{1'b1, 1'b1, 7'd0,  1'b0, 1'b1, 7'd0,  1'b0},
        '{1'b0, 1'b0, 7'd64, 1'b1, 1'b0, 7'd64, 1'b0},
        '{1'b1, 1'b0, 7'd1,  1'b0, 1'b0, 7'd0,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_tx = 1'b0, start_rx = 1'b0, toggle = 1'b0, dir = 1'b0;
    logic [AW:0] size_ep1 = '0, size_ep2 = '0;
    logic bit_stb = 1'b0, rx_bit = 1'b0, rx_eop = 1'b0;
    logic clr_tog = 1'b0, clr_crc = 1'b0, clr_size = 1'b0;
    logic tx_oe, tx_bit, tx_se0, rd_buf, wr_en, wr_buf, err_tog, err_crc, err_size, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic [AW+1:0] rx_count;

    logic [7:0] mem1 [64];
    logic [7:0] mem2 [64];
    logic [7:0] got1 [64];
    logic [7:0] got2 [64];
    logic capb [800];
    logic caps [800];
    logic expb [800];
    logic exps [800];
    int ncap, nexp, wr_cnt, done_cnt, cyc;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    assign rd_data = rd_buf ? mem2[rd_addr] : mem1[rd_addr];

    usb_dp_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
        .toggle(toggle), .dir(dir), .size_ep1(size_ep1), .size_ep2(size_ep2),
        .bit_stb(bit_stb), .tx_oe(tx_oe), .tx_bit(tx_bit), .tx_se0(tx_se0),
        .rd_buf(rd_buf), .rd_addr(rd_addr), .rd_data(rd_data), .rx_bit(rx_bit),
        .rx_eop(rx_eop), .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr_tog(clr_tog), .clr_crc(clr_crc), .clr_size(clr_size),
        .err_tog(err_tog), .err_crc(err_crc), .err_size(err_size), .done(done),
        .rx_count(rx_count)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            if (wr_buf) got2[wr_addr] = wr_data;
            else        got1[wr_addr] = wr_data;
            wr_cnt++;
        end
        if (done) done_cnt++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [6:0] other(input logic [6:0] v);
        return (v >= 7'd60) ? 7'd3 : v + 7'd3;
    endfunction

    // expected wire image from R1, R2, R6
    task automatic build_exp(input logic d, input logic tg, input int len);
        logic [15:0] c;
        logic [7:0]  pid, b;
        logic        fb;
        c = 16'hFFFF;
        nexp = 0;
        pid = tg ? 8'h4B : 8'hC3;
        for (int i = 0; i < 8; i++) begin expb[nexp] = (i == 7); exps[nexp] = 0; nexp++; end
        for (int i = 0; i < 8; i++) begin expb[nexp] = pid[i]; exps[nexp] = 0; nexp++; end
        for (int k = 0; k < len; k++) begin
            b = d ? mem1[k] : mem2[k];
            for (int i = 0; i < 8; i++) begin
                expb[nexp] = b[i]; exps[nexp] = 0; nexp++;
                fb = c[15] ^ b[i];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
            end
        end
        for (int i = 15; i >= 0; i--) begin expb[nexp] = ~c[i]; exps[nexp] = 0; nexp++; end
        for (int i = 0; i < 2; i++) begin expb[nexp] = 0; exps[nexp] = 1; nexp++; end
        expb[nexp] = 1; exps[nexp] = 0; nexp++;
    endtask

    task automatic do_tx(input logic d, input logic tg, input logic [6:0] len);
        logic lastdone;
        int   d0, bad;
        lastdone = 0;
        toggle = tg; dir = d;
        size_ep1 = d ? len : other(len);
        size_ep2 = d ? other(len) : len;
        build_exp(d, tg, int'(len));
        d0 = done_cnt;
        ncap = 0;
        @(negedge clk) start_tx = 1;
        @(negedge clk) start_tx = 0;
        for (int k = 0; k < 800; k++) begin
            if (!tx_oe) break;
            capb[ncap] = tx_bit; caps[ncap] = tx_se0; ncap++;
            bit_stb = 1;
            @(negedge clk) bit_stb = 0;
            lastdone = done;
            repeat (2) @(negedge clk);
        end
        bad = -1;
        for (int i = 0; i < nexp; i++)
            if (bad < 0 && (i >= ncap || capb[i] != expb[i] || caps[i] != exps[i])) bad = i;
        // R1 R2 R3 R6: complete wire image
        chk(bad < 0 && ncap == nexp, "R1/R2/R3/R6 tx stream", (bad < 0) ? ncap : bad, nexp);
        // R9: single done pulse right after the J bit time
        chk(lastdone && (done_cnt - d0) == 1, "R9 tx done", done_cnt - d0, 1);
    endtask

    task automatic do_rx(input logic d, input logic tg, input logic [6:0] lim, input logic fl);
        for (int i = 0; i < 64; i++) begin got1[i] = 8'h00; got2[i] = 8'h00; end
        wr_cnt = 0;
        toggle = tg; dir = d;
        size_ep1 = d ? other(lim) : lim;
        size_ep2 = d ? lim : other(lim);
        @(negedge clk) start_rx = 1;
        @(negedge clk) start_rx = 0;
        for (int k = 0; k < ncap - 3; k++) begin
            rx_bit = capb[k] ^ (fl && k == 19);
            bit_stb = 1;
            @(negedge clk) bit_stb = 0; rx_bit = 0;
            @(negedge clk);
        end
        rx_eop = 1;
        @(negedge clk) rx_eop = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk) begin clr_tog = 1; clr_crc = 1; clr_size = 1; end
        @(negedge clk) begin clr_tog = 0; clr_crc = 0; clr_size = 0; end
    endtask

    initial begin
        int len, lim, nw, bad;
        logic [7:0] e, g;
        for (int i = 0; i < 64; i++) begin
            mem1[i] = 8'(i * 7 + 1);
            mem2[i] = ~8'(i * 13 + 5);
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!tx_oe && !tx_bit && !tx_se0, "R10 tx idle", tx_oe, 0);
        chk(!wr_en && !done, "R10 no strobes", wr_en + done, 0);
        chk(!err_tog && !err_crc && !err_size, "R10 flags", err_tog + err_crc + err_size, 0);
        chk(rx_count == 0, "R10 rx_count", rx_count, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            len = int'(VECS[v].txlen);
            lim = int'(VECS[v].rxlim);
            clear_all();
            do_tx(VECS[v].txdir, VECS[v].txtog, VECS[v].txlen);
            done_cnt = 0;
            do_rx(VECS[v].rxdir, VECS[v].rxtog, VECS[v].rxlim, VECS[v].flip);
            chk(done_cnt == 1, "R9 rx done", done_cnt, 1);
            chk(err_tog == (VECS[v].txtog != VECS[v].rxtog), "R5 toggle flag", err_tog,
                int'(VECS[v].txtog != VECS[v].rxtog));
            chk(err_crc == VECS[v].flip, "R6 crc flag", err_crc, VECS[v].flip);
            chk(err_size == (len > lim), "R7 size flag", err_size, int'(len > lim));
            chk(int'(rx_count) == len, "R9 rx_count", rx_count, len);
            nw = (VECS[v].txtog != VECS[v].rxtog) ? 0 : ((len < lim) ? len : lim);
            bad = -1;
            for (int i = 0; i < nw; i++) begin
                e = (VECS[v].txdir ? mem1[i] : mem2[i]) ^ ((VECS[v].flip && i == 0) ? 8'h08 : 8'h00);
                g = VECS[v].rxdir ? got2[i] : got1[i];
                if (bad < 0 && g != e) bad = i;
            end
            // R4 R5 R7: writes land in the reversed buffer, in order, within the limit
            chk(bad < 0 && wr_cnt == nw, "R4/R5/R7 rx writes", (bad < 0) ? wr_cnt : bad, nw);
        end

        // R8: flags merge across packets when not cleared
        clear_all();
        do_tx(1'b1, 1'b1, 7'd2);
        do_rx(1'b1, 1'b0, 7'd8, 1'b0);
        chk(err_tog && !err_crc, "R8 first cause", err_tog, 1);
        do_tx(1'b1, 1'b0, 7'd2);
        do_rx(1'b1, 1'b0, 7'd8, 1'b0);
        chk(err_tog, "R8 kept after clean packet", err_tog, 1);
        do_tx(1'b0, 1'b0, 7'd3);
        do_rx(1'b0, 1'b0, 7'd8, 1'b1);
        chk(err_tog && err_crc, "R8 merged causes", err_tog + err_crc, 2);
        @(negedge clk) clr_tog = 1;
        @(negedge clk) clr_tog = 0;
        chk(!err_tog && err_crc, "R8 single clear", err_crc - err_tog, 1);
        @(negedge clk) clr_crc = 1;
        @(negedge clk) clr_crc = 0;
        chk(!err_crc, "R8 crc clear", err_crc, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule